// File: doc/BRIEF.md
# Linear Classifier Window Scorer

This unit decides whether a single 64 by 128 pixel detection window holds a person. Its input is the window's normalised gradient-histogram descriptor. The descriptor is built from 16 by 16 pixel blocks placed on an 8 pixel grid, each block made of four 8 by 8 cells with nine orientation bins per cell. That gives 7 by 15 blocks of 36 values, or 3780 features per window.

Features arrive one per beat as unsigned Q0.8 values. Each feature is multiplied by a signed Q8.8 weight, which is a real weight times 256 stored as an integer. The weights sit in an internal store. The products are summed in a 32-bit accumulator, and a bias scaled to the same units is added. The total is compared with a programmable threshold. The unit reports the raw score, the person decision, a descriptor-length error flag and the tag of the window.

Eight copies of the unit can score eight windows side by side. Each copy holds the same weight image, so one broadcast write sequence loads all of them. The store accepts writes only between windows.

Top module: `svm_window_scorer`

## Requirements
- R1: After reset, `res_valid`, `busy`, `res_person`, `res_len_err` and `res_score` are all zero.
- R2: When the window is idle, a write with `wr_en`=1 and `wr_bias`=0 stores `wr_data` as the weight for feature position `wr_addr`. Position 0 is the first beat of a window.
- R3: When the window is idle, a write with `wr_en`=1 and `wr_bias`=1 stores `wr_data` as the bias.
- R4: The score is the sum, over the accepted beats of the window, of feature (unsigned, zero-extended) times weight (signed 16-bit) for that beat position, plus the bias shifted left by 8. The sum wraps modulo 2^32 in two's complement.
- R5: `res_valid` is high for exactly the one cycle after the clock edge that accepts a beat with `feat_last`=1. It is low in every other cycle.
- R6: `res_person` is 1 exactly when the signed score is strictly greater than the signed `thresh` presented with the last beat. A score equal to the threshold gives 0.
- R7: Each window starts from a zero accumulator. A window may begin on the cycle right after the previous last beat, and its score is unaffected by the earlier window.
- R8: `res_len_err` is 1 exactly when the window held a number of beats other than 3780. Beats past position 3779 add nothing to the score.
- R9: A write is ignored when it comes in a cycle where `feat_valid`=1, or while a window is open. A window is open from its first accepted beat until its last.
- R10: `res_tag` equals the `win_tag` presented with the last beat.
- R11: `busy` is 1 while a window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_valid | input | 1 | Feature beat present |
| feat_data | input | 8 | Unsigned Q0.8 feature |
| feat_last | input | 1 | Final beat of the window |
| win_tag | input | 8 | Window identifier, taken with the last beat |
| thresh | input | 32 | Signed decision threshold in accumulator units |
| wr_en | input | 1 | Coefficient write strobe |
| wr_bias | input | 1 | 1 selects the bias, 0 selects a weight |
| wr_addr | input | 12 | Weight position |
| wr_data | input | 16 | Signed Q8.8 coefficient |
| busy | output | 1 | Window in progress |
| res_valid | output | 1 | Result strobe |
| res_score | output | 32 | Signed raw score |
| res_person | output | 1 | Person decision |
| res_len_err | output | 1 | Descriptor length mismatch |
| res_tag | output | 8 | Tag of the scored window |

## Verification
The assertions check these properties on every cycle:
- The beat counter returns to zero and the window closes after each last beat.
- The counter never exceeds its saturation point.
- The result strobe follows a last beat by one cycle.
- The accumulator is clear whenever a result is shown.
- The error flag appears only with a result.
- The bias holds while writes are locked.

Only the bench's scenarios can show the arithmetic. These scenarios check:
- Whole dot products against random weights.
- The strict-versus-equal threshold edge.
- Back-to-back windows.
- Short and over-long descriptors.
- Writes attempted inside a window, which must leave no trace in a later window's score.

// File: rtl/svm_pkg.sv
package svm_pkg;
    localparam int FEAT_W = 8;
    localparam int COEF_W = 16;
    localparam int FRAC_W = 8;
    localparam int ACC_W  = 32;

    typedef logic [FEAT_W-1:0]        feat_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
endpackage

// File: rtl/svm_coef_store.sv
module svm_coef_store
    import svm_pkg::*;
#(
    parameter int DEPTH = 3780,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bias,
    input  logic [AW-1:0] wr_addr,
    input  coef_t         wr_data,
    input  logic          lock,
    input  logic [AW-1:0] rd_addr,
    output coef_t         rd_coef,
    output coef_t         bias
);
    localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

    coef_t mem [DEPTH];
    coef_t bias_d, bias_q;
    logic  wt_we;

    assign wt_we = wr_en && !wr_bias && !lock && (wr_addr <= TOP_ADDR);

    always_ff @(posedge clk) begin
        if (wt_we) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_coef = '0;
        if (rd_addr <= TOP_ADDR) begin
            rd_coef = mem[rd_addr];
        end
    end

    always_comb begin
        bias_d = bias_q;
        if (wr_en && wr_bias && !lock) begin
            bias_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bias_q <= '0;
        end else begin
            bias_q <= bias_d;
        end
    end

    assign bias = bias_q;

    p_bias_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(bias_q));
    p_bias_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bias && !lock) |=> (bias_q == $past(wr_data)));
endmodule

// File: rtl/svm_seq_ctrl.sv
module svm_seq_ctrl #(
    parameter int COUNT = 3780,
    parameter int CW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat,
    input  logic          last,
    output logic [CW-1:0] idx,
    output logic          open,
    output logic          len_ok
);
    localparam logic [CW-1:0] LAST_IDX = CW'(COUNT - 1);
    localparam logic [CW-1:0] SAT_IDX  = CW'(COUNT);

    typedef struct packed {
        logic [CW-1:0] idx;
        logic          open;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (beat) begin
            if (last) begin
                st_d.idx  = '0;
                st_d.open = 1'b0;
            end else begin
                st_d.open = 1'b1;
                if (st_q.idx != SAT_IDX) begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx    = st_q.idx;
    assign open   = st_q.open;
    assign len_ok = (st_q.idx == LAST_IDX);

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && last) |=> (st_q.idx == '0 && !st_q.open));
    p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= SAT_IDX);
    p_busy_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !last) |=> st_q.open);
endmodule

// File: rtl/svm_mac.sv
module svm_mac
    import svm_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             last,
    input  feat_t            feat,
    input  coef_t            coef,
    input  coef_t            bias,
    input  acc_t             thresh,
    input  logic [TAG_W-1:0] tag,
    input  logic             len_ok,
    output logic             res_valid,
    output acc_t             res_score,
    output logic             res_person,
    output logic             res_len_err,
    output logic [TAG_W-1:0] res_tag
);
    localparam int PW = FEAT_W + 1 + COEF_W;

    typedef struct packed {
        acc_t             acc;
        logic             valid;
        acc_t             score;
        logic             person;
        logic             err;
        logic [TAG_W-1:0] tag;
    } mac_t;

    mac_t st_d, st_q;
    logic signed [PW-1:0] prod;
    acc_t prod_ext, bias_ext, sum, total;

    always_comb begin
        prod     = $signed({1'b0, feat}) * coef;
        prod_ext = {{(ACC_W - PW){prod[PW-1]}}, prod};
        bias_ext = {{(ACC_W - COEF_W - FRAC_W){bias[COEF_W-1]}}, bias, {FRAC_W{1'b0}}};
        sum      = st_q.acc + prod_ext;
        total    = sum + bias_ext;

        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        if (beat) begin
            if (last) begin
                st_d.acc    = '0;
                st_d.valid  = 1'b1;
                st_d.score  = total;
                st_d.person = (total > thresh);
                st_d.err    = !len_ok;
                st_d.tag    = tag;
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid   = st_q.valid;
    assign res_score   = st_q.score;
    assign res_person  = st_q.person;
    assign res_len_err = st_q.err;
    assign res_tag     = st_q.tag;

    p_valid_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(beat && last));
    p_acc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.acc == '0));
    p_err_with_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> !st_q.err);
endmodule

// File: rtl/svm_window_scorer.sv
module svm_window_scorer
    import svm_pkg::*;
#(
    parameter int FEAT_COUNT = 3780,
    parameter int TAG_W      = 8,
    localparam int IDX_W     = $clog2(FEAT_COUNT + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    feat_valid,
    input  logic [FEAT_W-1:0]       feat_data,
    input  logic                    feat_last,
    input  logic [TAG_W-1:0]        win_tag,
    input  logic signed [ACC_W-1:0] thresh,
    input  logic                    wr_en,
    input  logic                    wr_bias,
    input  logic [IDX_W-1:0]        wr_addr,
    input  logic signed [COEF_W-1:0] wr_data,
    output logic                    busy,
    output logic                    res_valid,
    output logic signed [ACC_W-1:0] res_score,
    output logic                    res_person,
    output logic                    res_len_err,
    output logic [TAG_W-1:0]        res_tag
);
    logic [IDX_W-1:0] idx;
    logic             open, len_ok, lock;
    coef_t            coef, bias;

    assign lock = open || feat_valid;
    assign busy = open;

    svm_seq_ctrl #(.COUNT(FEAT_COUNT), .CW(IDX_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat   (feat_valid),
        .last   (feat_last),
        .idx    (idx),
        .open   (open),
        .len_ok (len_ok)
    );

    svm_coef_store #(.DEPTH(FEAT_COUNT), .AW(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bias (wr_bias),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lock    (lock),
        .rd_addr (idx),
        .rd_coef (coef),
        .bias    (bias)
    );

    svm_mac #(.TAG_W(TAG_W)) u_mac (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (feat_valid),
        .last        (feat_last),
        .feat        (feat_data),
        .coef        (coef),
        .bias        (bias),
        .thresh      (thresh),
        .tag         (win_tag),
        .len_ok      (len_ok),
        .res_valid   (res_valid),
        .res_score   (res_score),
        .res_person  (res_person),
        .res_len_err (res_len_err),
        .res_tag     (res_tag)
    );
endmodule

// File: tb/svm_window_scorer_test.sv
module svm_window_scorer_test;
    localparam int N = 3780;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               feat_valid = 1'b0, feat_last = 1'b0;
    logic [7:0]         feat_data = '0, win_tag = '0;
    logic signed [31:0] thresh = '0;
    logic               wr_en = 1'b0, wr_bias = 1'b0;
    logic [11:0]        wr_addr = '0;
    logic signed [15:0] wr_data = '0;
    logic               busy, res_valid, res_person, res_len_err;
    logic signed [31:0] res_score;
    logic [7:0]         res_tag;

    svm_window_scorer uut (
        .clk(clk), .rst_n(rst_n), .feat_valid(feat_valid), .feat_data(feat_data),
        .feat_last(feat_last), .win_tag(win_tag), .thresh(thresh), .wr_en(wr_en),
        .wr_bias(wr_bias), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
        .res_valid(res_valid), .res_score(res_score), .res_person(res_person),
        .res_len_err(res_len_err), .res_tag(res_tag)
    );

    int errors = 0;
    int checks = 0;
    logic signed [15:0] wmodel [N];
    logic signed [15:0] bmodel = '0;
    logic [7:0]         fbuf [4000];
    logic signed [31:0] q_score [$];
    logic               q_person [$];
    logic               q_err [$];
    logic [7:0]         q_tag [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic signed [31:0] model_score(input int n);
        logic signed [31:0] a = '0;
        for (int i = 0; i < n && i < N; i++) begin
            a = a + $signed({1'b0, fbuf[i]}) * wmodel[i];
        end
        a = a + ($signed({{16{bmodel[15]}}, bmodel}) <<< 8);
        return a;
    endfunction

    always @(posedge clk) begin
        #2;
        if (rst_n && res_valid) begin
            if (q_score.size() == 0) begin
                chk(1'b0, "R5", "unexpected result strobe", 1, 0);
            end else begin
                logic signed [31:0] es;
                logic ep, ee;
                logic [7:0] et;
                es = q_score.pop_front();
                ep = q_person.pop_front();
                ee = q_err.pop_front();
                et = q_tag.pop_front();
                chk(res_score == es, "R4", "score", res_score, es);
                chk(res_person == ep, "R6", "decision", res_person, ep);
                chk(res_len_err == ee, "R8", "length error", res_len_err, ee);
                chk(res_tag == et, "R10", "tag", res_tag, et);
            end
        end
    end

    task automatic fill_random(input int n);
        for (int i = 0; i < n; i++) fbuf[i] = 8'($urandom);
    endtask

    task automatic idle();
        @(negedge clk);
        feat_valid = 1'b0;
        feat_last  = 1'b0;
        wr_en      = 1'b0;
        wr_bias    = 1'b0;
    endtask

    task automatic send_window(input int n, input logic [7:0] tag,
                               input logic signed [31:0] thr, input bit inject);
        logic signed [31:0] e;
        e = model_score(n);
        q_score.push_back(e);
        q_person.push_back(e > thr);
        q_err.push_back(n != N);
        q_tag.push_back(tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 2) chk(busy == 1'b1, "R11", "busy inside window", busy, 1);
            feat_valid = 1'b1;
            feat_data  = fbuf[i];
            feat_last  = (i == n - 1);
            win_tag    = tag;
            thresh     = thr;
            wr_en      = 1'b0;
            wr_bias    = 1'b0;
            if (inject && (i == 0 || i == 5 || i == n - 1)) begin
                wr_en   = 1'b1;
                wr_addr = 12'(i);
                wr_data = ~wmodel[i];
            end
            if (inject && i == 10) begin
                wr_en   = 1'b1;
                wr_bias = 1'b1;
                wr_data = ~bmodel;
            end
        end
    endtask

    task automatic write_coef(input bit is_bias, input int addr, input logic signed [15:0] d);
        @(negedge clk);
        feat_valid = 1'b0;
        feat_last  = 1'b0;
        wr_en      = 1'b1;
        wr_bias    = is_bias;
        wr_addr    = 12'(addr);
        wr_data    = d;
        if (is_bias) bmodel = d;
        else wmodel[addr] = d;
    endtask

    task automatic settle();
        idle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic signed [31:0] e;
        void'($urandom(32'h5EED_2024));
        repeat (5) @(negedge clk);
        chk(res_valid == 1'b0, "R1", "reset valid", res_valid, 0);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(res_score == 0, "R1", "reset score", res_score, 0);
        chk(res_person == 1'b0 && res_len_err == 1'b0, "R1", "reset flags",
            {res_person, res_len_err}, 0);
        rst_n = 1'b1;

        // R2 R3: load a random weight image and bias while idle
        for (int i = 0; i < N; i++) write_coef(1'b0, i, 16'($urandom));
        write_coef(1'b1, 0, 16'($urandom));
        idle();

        // R4: random window
        fill_random(N);
        send_window(N, 8'h11, $signed($urandom), 1'b0);
        settle();
        chk(busy == 1'b0, "R11", "busy after window", busy, 0);

        // R7: back-to-back windows with different contents
        fill_random(N);
        send_window(N, 8'h22, 32'sd0, 1'b0);
        fill_random(N);
        send_window(N, 8'h33, -32'sd5000, 1'b0);
        settle();

        // R6: threshold equal to the score, then one below
        fill_random(N);
        e = model_score(N);
        send_window(N, 8'h44, e, 1'b0);
        send_window(N, 8'h45, e - 1, 1'b0);
        settle();

        // R4: all-zero features give only the scaled bias
        for (int i = 0; i < N; i++) fbuf[i] = 8'h00;
        send_window(N, 8'h55, 32'sd0, 1'b0);
        settle();

        // R8: short and over-long descriptors
        fill_random(4000);
        send_window(100, 8'h66, 32'sd0, 1'b0);
        settle();
        send_window(N + 10, 8'h67, 32'sd0, 1'b0);
        settle();

        // R9: writes attempted during a window, then a clean window exposes them
        fill_random(N);
        send_window(N, 8'h77, 32'sd0, 1'b1);
        settle();
        fill_random(N);
        send_window(N, 8'h78, 32'sd0, 1'b0);
        settle();

        // R2 R3: idle rewrite takes effect
        write_coef(1'b0, 0, 16'sh7FFF);
        write_coef(1'b1, 0, -16'sd300);
        idle();
        for (int i = 0; i < N; i++) fbuf[i] = 8'($urandom);
        fbuf[0] = 8'hFF;
        send_window(N, 8'h88, 32'sd0, 1'b0);
        settle();

        chk(q_score.size() == 0, "R5", "results outstanding", q_score.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule